// File: doc/BRIEF.md
# Audio Ring Pointer and Interrupt Engine

This block keeps the chunk pointers for two audio ring buffers, one for capture and one for playback, and raises interrupts as the hardware side moves through each ring. Data moves in 32-byte chunks. An external bus mover, outside this block, reports each finished chunk with a one-cycle strobe (`cap_chunk_done`, `play_chunk_done`). The block advances the hardware-owned pointer of that channel, wraps it at the programmed ring length, and compares the new value with a trigger pointer under a power-of-two mask. On the capture channel hardware owns the write pointer and software owns the read pointer. On the playback channel the two roles are swapped.

Each channel runs a three-state machine. `CH_IDLE` means DMA is off. `CH_RUN` means chunks are accepted. `CH_STALL` means the ring is blocked: capture is full, or playback is empty. The transitions are: **enable** (`CH_IDLE`→`CH_RUN`, on a control write with the enable bit set), **block** (`CH_RUN`→`CH_STALL`, on overflow or underflow), **unblock** (`CH_STALL`→`CH_RUN`, once software moves its pointer), and **disable** (any state→`CH_IDLE`, on a control write with enable clear or with the reset bit set). A shared status register collects trigger, fault and link-error events. Software clears status bits by writing 1 to them. A mask register selects which status bits drive `irq`. Playback samples pass through a holding register. That register outputs zero while the channel is off and repeats the last sample while the channel is stalled.

Top module: `ring_dma_engine`

## Requirements
- R1: After reset, all four registers read zero, `irq`, `cap_run` and `play_run` are 0, and `play_smp_out` is 0.
- R2: Register write/read address 0 selects the capture control word and address 1 the playback control word. Control word fields: bit 31 reset, bits 30:28 size, bit 27 enable, bits 26:24 trigger-mask code, bits 23:16 trigger pointer, bits 15:8 read pointer, bits 7:0 write pointer. Bit 31 always reads 0. A write with enable set loads every field except the hardware-owned pointer, which is the capture write pointer or the playback read pointer.
- R3: In `CH_RUN`, each chunk strobe moves the hardware pointer forward by one, modulo 2^(size+1) chunks. Size codes 0 and 1 act as 2, so the ring length runs from 8 to 256 chunks.
- R4: When the hardware pointer advances to value h, the channel's trigger status bit is set if (h & m) == (tptr & m), where m = (1 << (8 - code)) - 1. Code 0 gives one event per 256 chunks and code 7 one event per 2 chunks. Capture uses status bit 1 and playback uses status bit 3.
- R5: A capture chunk strobe in `CH_RUN` whose advanced pointer would equal the read pointer sets status bit 0. The write pointer does not move, and the channel enters `CH_STALL`. It drops further chunks until the read pointer no longer equals the next write position.
- R6: A playback channel in `CH_RUN` whose read pointer equals its write pointer sets status bit 2 once and enters `CH_STALL`. The read pointer then holds until software moves the write pointer.
- R7: A control write with enable clear sends the channel to `CH_IDLE` and loads both pointer fields from the write data, so writing zeros returns the hardware pointer to 0. Chunk strobes have no effect in `CH_IDLE`.
- R8: A control write with bit 31 set clears every field of that channel and sends it to `CH_IDLE`.
- R9: The status register is at address 2. It implements bits 0 to 3 and bit 15, and bit 15 is set by `link_err`. Writing 1 to a bit clears it. A hardware set in the same cycle as a clear leaves the bit at 1.
- R10: The mask register is at address 3 and implements the same bits as status. `irq` is 1 exactly when some status bit and its mask bit are both 1.
- R11: `play_smp_out` becomes 0 after a cycle with playback in `CH_IDLE`. It takes `play_smp_in` after a `CH_RUN` cycle with `play_smp_vld` high. It is unchanged after a `CH_STALL` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address (0 capture ctl, 1 playback ctl, 2 status, 3 mask) |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address, same map |
| reg_rdata | output | 32 | Read data, combinational |
| cap_chunk_done | input | 1 | One capture chunk finished |
| play_chunk_done | input | 1 | One playback chunk finished |
| link_err | input | 1 | Link error event |
| play_smp_vld | input | 1 | Playback sample valid |
| play_smp_in | input | 16 | Playback sample from the ring |
| play_smp_out | output | 16 | Sample sent to the converter |
| cap_run | output | 1 | Capture channel in `CH_RUN` |
| play_run | output | 1 | Playback channel in `CH_RUN` |
| irq | output | 1 | Masked interrupt |

## Verification
Two functions can land on the same status bit in the same cycle: a hardware event setting it, and a software write-1-to-clear. The bench provokes this in two ways. It raises `link_err` while writing 1 to bit 15. It also issues a trigger-producing chunk strobe while clearing bit 1 in the same cycle, repeated over a full ring pass. It judges the result by reading status back: the bit must still be 1 after the collision and only a later clear with no event may remove it. Randomised traffic also drives control writes against chunk strobes. Each cycle is compared with a requirement-level model.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
    parameter int PTR_W  = 8;
    parameter int CODE_W = 3;
    parameter int STAT_W = 16;

    localparam int ST_CAP_OVF   = 0;
    localparam int ST_CAP_TRIG  = 1;
    localparam int ST_PLAY_UDF  = 2;
    localparam int ST_PLAY_TRIG = 3;
    localparam int ST_LINK_ERR  = 15;

    localparam logic [STAT_W-1:0] STAT_IMPL =
        (STAT_W'(1) << ST_CAP_OVF)  | (STAT_W'(1) << ST_CAP_TRIG) |
        (STAT_W'(1) << ST_PLAY_UDF) | (STAT_W'(1) << ST_PLAY_TRIG) |
        (STAT_W'(1) << ST_LINK_ERR);

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_STALL = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic              clr;
        logic [CODE_W-1:0] size;
        logic              en;
        logic [CODE_W-1:0] tcode;
        logic [PTR_W-1:0]  tptr;
        logic [PTR_W-1:0]  rptr;
        logic [PTR_W-1:0]  wptr;
    } ctl_word_t;

    localparam int CTL_W = $bits(ctl_word_t);
endpackage

// File: rtl/ring_chan.sv
module ring_chan
    import ring_dma_pkg::*;
#(
    parameter bit IS_CAPTURE = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctl_wr,
    input  ctl_word_t ctl_wdata,
    input  logic      chunk_done,
    output ctl_word_t ctl_q,
    output ch_state_e state_o,
    output logic      trig_o,
    output logic      fault_o
);
    localparam logic [3:0] PW4 = 4'(PTR_W);
    localparam logic [CODE_W-1:0] MIN_SIZE = CODE_W'(2);

    ch_state_e         state_q, state_d;
    logic [CODE_W-1:0] size_q, tcode_q;
    logic              en_q;
    logic [PTR_W-1:0]  tptr_q, hw_q, sw_q;

    logic [CODE_W-1:0] eff_size;
    logic [PTR_W:0]    ring_span, sect_span;
    logic [PTR_W-1:0]  wrap_mask, sel_mask, hw_next;
    logic              blocked, advance, fault;
    logic [PTR_W-1:0]  wr_hw_field, wr_sw_field;

    // ring length and trigger-section masks
    assign eff_size  = (size_q < MIN_SIZE) ? MIN_SIZE : size_q;
    assign ring_span = {{PTR_W{1'b0}}, 1'b1} << ({1'b0, eff_size} + 4'd1);
    assign wrap_mask = ring_span[PTR_W-1:0] - {{(PTR_W-1){1'b0}}, 1'b1};
    assign sect_span = {{PTR_W{1'b0}}, 1'b1} << (PW4 - {1'b0, tcode_q});
    assign sel_mask  = sect_span[PTR_W-1:0] - {{(PTR_W-1){1'b0}}, 1'b1};
    assign hw_next   = (hw_q + {{(PTR_W-1){1'b0}}, 1'b1}) & wrap_mask;

    // direction-specific pointer ownership
    generate
        if (IS_CAPTURE) begin : g_cap
            assign blocked     = (hw_next == sw_q);
            assign wr_hw_field = ctl_wdata.wptr;
            assign wr_sw_field = ctl_wdata.rptr;
            assign ctl_q = '{clr: 1'b0, size: size_q, en: en_q, tcode: tcode_q,
                             tptr: tptr_q, rptr: sw_q, wptr: hw_q};
        end else begin : g_play
            assign blocked     = (hw_q == sw_q);
            assign wr_hw_field = ctl_wdata.rptr;
            assign wr_sw_field = ctl_wdata.wptr;
            assign ctl_q = '{clr: 1'b0, size: size_q, en: en_q, tcode: tcode_q,
                             tptr: tptr_q, rptr: hw_q, wptr: sw_q};
        end
    endgenerate

    // next-state and action decode
    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        fault   = 1'b0;
        if (ctl_wr) begin
            if (ctl_wdata.clr || !ctl_wdata.en) begin
                state_d = CH_IDLE;
            end else if (state_q == CH_IDLE) begin
                state_d = CH_RUN;
            end
        end else begin
            unique case (state_q)
                CH_IDLE: state_d = CH_IDLE;
                CH_RUN: begin
                    if (IS_CAPTURE) begin
                        if (chunk_done) begin
                            if (blocked) begin
                                state_d = CH_STALL;
                                fault   = 1'b1;
                            end else begin
                                advance = 1'b1;
                            end
                        end
                    end else begin
                        if (blocked) begin
                            state_d = CH_STALL;
                            fault   = 1'b1;
                        end else if (chunk_done) begin
                            advance = 1'b1;
                        end
                    end
                end
                CH_STALL: begin
                    if (!blocked) state_d = CH_RUN;
                end
                default: state_d = CH_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // field and pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q  <= '0;
            tcode_q <= '0;
            en_q    <= 1'b0;
            tptr_q  <= '0;
            hw_q    <= '0;
            sw_q    <= '0;
        end else if (ctl_wr) begin
            if (ctl_wdata.clr) begin
                size_q  <= '0;
                tcode_q <= '0;
                en_q    <= 1'b0;
                tptr_q  <= '0;
                hw_q    <= '0;
                sw_q    <= '0;
            end else begin
                size_q  <= ctl_wdata.size;
                tcode_q <= ctl_wdata.tcode;
                en_q    <= ctl_wdata.en;
                tptr_q  <= ctl_wdata.tptr;
                sw_q    <= wr_sw_field;
                if (!ctl_wdata.en) hw_q <= wr_hw_field;
            end
        end else if (advance) begin
            hw_q <= hw_next;
        end
    end

    assign state_o = state_q;
    assign fault_o = fault;
    assign trig_o  = advance && ((hw_next & sel_mask) == (tptr_q & sel_mask));

    p_reset_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata.clr) |=> (state_q == CH_IDLE && hw_q == '0 && sw_q == '0));
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && !ctl_wr) |=> $stable(hw_q));
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_STALL && !ctl_wr) |=> $stable(hw_q));
    p_adv_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && !ctl_wr && chunk_done && !blocked) |=> (hw_q != $past(hw_q)));
endmodule

// File: rtl/ring_irq.sv
module ring_irq
    import ring_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic [STAT_W-1:0] set_vec,
    output logic [STAT_W-1:0] status_q,
    output logic [STAT_W-1:0] mask_q,
    output logic              irq
);
    logic [STAT_W-1:0] clr_vec;

    assign clr_vec = stat_wr ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= ((status_q & ~clr_vec) | set_vec) & STAT_IMPL;
            if (mask_wr) mask_q <= wdata & STAT_IMPL;
        end
    end

    assign irq = |(status_q & mask_q);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));
    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_wr && set_vec == '0) |=> $stable(status_q));
endmodule

// File: rtl/play_hold.sv
module play_hold
    import ring_dma_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ch_state_e        state,
    input  logic             vld,
    input  logic [SMP_W-1:0] din,
    output logic [SMP_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else begin
            unique case (state)
                CH_IDLE:  dout <= '0;
                CH_RUN:   if (vld) dout <= din;
                CH_STALL: dout <= dout;
                default:  dout <= '0;
            endcase
        end
    end

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE) |=> (dout == '0));
    p_stall_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_STALL) |=> $stable(dout));
endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine
    import ring_dma_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_waddr,
    input  logic [31:0]      reg_wdata,
    input  logic [1:0]       reg_raddr,
    output logic [31:0]      reg_rdata,
    input  logic             cap_chunk_done,
    input  logic             play_chunk_done,
    input  logic             link_err,
    input  logic             play_smp_vld,
    input  logic [SMP_W-1:0] play_smp_in,
    output logic [SMP_W-1:0] play_smp_out,
    output logic             cap_run,
    output logic             play_run,
    output logic             irq
);
    localparam logic [1:0] A_CAP  = 2'd0;
    localparam logic [1:0] A_PLAY = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_MASK = 2'd3;

    ctl_word_t         wr_word, cap_ctl, play_ctl;
    ch_state_e         cap_state, play_state;
    logic              cap_trig, cap_fault, play_trig, play_fault;
    logic [STAT_W-1:0] set_vec, status_q, mask_q;

    assign wr_word = ctl_word_t'(reg_wdata[CTL_W-1:0]);

    ring_chan #(.IS_CAPTURE(1'b1)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(reg_wr && reg_waddr == A_CAP), .ctl_wdata(wr_word),
        .chunk_done(cap_chunk_done), .ctl_q(cap_ctl), .state_o(cap_state),
        .trig_o(cap_trig), .fault_o(cap_fault)
    );

    ring_chan #(.IS_CAPTURE(1'b0)) u_play (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(reg_wr && reg_waddr == A_PLAY), .ctl_wdata(wr_word),
        .chunk_done(play_chunk_done), .ctl_q(play_ctl), .state_o(play_state),
        .trig_o(play_trig), .fault_o(play_fault)
    );

    always_comb begin
        set_vec = '0;
        set_vec[ST_CAP_OVF]   = cap_fault;
        set_vec[ST_CAP_TRIG]  = cap_trig;
        set_vec[ST_PLAY_UDF]  = play_fault;
        set_vec[ST_PLAY_TRIG] = play_trig;
        set_vec[ST_LINK_ERR]  = link_err;
    end

    ring_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .stat_wr(reg_wr && reg_waddr == A_STAT),
        .mask_wr(reg_wr && reg_waddr == A_MASK),
        .wdata(reg_wdata[STAT_W-1:0]), .set_vec(set_vec),
        .status_q(status_q), .mask_q(mask_q), .irq(irq)
    );

    play_hold #(.SMP_W(SMP_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .state(play_state),
        .vld(play_smp_vld), .din(play_smp_in), .dout(play_smp_out)
    );

    always_comb begin
        unique case (reg_raddr)
            A_CAP:   reg_rdata = 32'(cap_ctl);
            A_PLAY:  reg_rdata = 32'(play_ctl);
            A_STAT:  reg_rdata = 32'(status_q);
            default: reg_rdata = 32'(mask_q);
        endcase
    end

    assign cap_run  = (cap_state == CH_RUN);
    assign play_run = (play_state == CH_RUN);

    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> !irq);
    p_no_wr_ctl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && cap_state == CH_IDLE) |=> $stable(cap_ctl));
endmodule

// File: tb/ring_dma_engine_tb_top.sv
`timescale 1ns/100ps
module ring_dma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_waddr, reg_raddr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        cap_chunk_done, play_chunk_done, link_err, play_smp_vld;
    logic [15:0] play_smp_in, play_smp_out;
    logic        cap_run, play_run, irq;

    always #5 clk = ~clk;

    ring_dma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .cap_chunk_done(cap_chunk_done), .play_chunk_done(play_chunk_done),
        .link_err(link_err), .play_smp_vld(play_smp_vld), .play_smp_in(play_smp_in),
        .play_smp_out(play_smp_out), .cap_run(cap_run), .play_run(play_run), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;

    // requirement-level model: index 0 capture, 1 playback
    logic [2:0]  m_size [2];
    logic        m_en   [2];
    logic [2:0]  m_tc   [2];
    logic [7:0]  m_tp   [2];
    logic [7:0]  m_rp   [2];
    logic [7:0]  m_wp   [2];
    int          m_st   [2];   // 0 idle, 1 run, 2 stall
    logic [15:0] m_stat, m_mask, m_smp;

    function automatic int ring_len(logic [2:0] s);
        int e = (s < 2) ? 2 : int'(s);
        return 1 << (e + 1);
    endfunction

    function automatic bit trig_hit(logic [7:0] h, logic [7:0] t, logic [2:0] c);
        int m = (1 << (8 - int'(c))) - 1;
        return ((int'(h) & m) == (int'(t) & m));
    endfunction

    function automatic logic [31:0] exp_reg(int a);
        if (a < 2) return {1'b0, m_size[a], m_en[a], m_tc[a], m_tp[a], m_rp[a], m_wp[a]};
        if (a == 2) return {16'h0, m_stat};
        return {16'h0, m_mask};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic read_reg(int a, output logic [31:0] v);
        reg_raddr = 2'(a);
        #0.5;
        v = reg_rdata;
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_size[c] = '0; m_en[c] = 1'b0; m_tc[c] = '0; m_tp[c] = '0;
            m_rp[c] = '0; m_wp[c] = '0; m_st[c] = 0;
        end
        m_stat = '0; m_mask = '0; m_smp = '0;
    endtask

    task automatic step(string tag, bit wr, logic [1:0] wa, logic [31:0] wd,
                        bit cd, bit pd, bit le, bit sv, logic [15:0] si);
        logic [15:0] setv = '0;
        logic [15:0] clr;
        int pre_play = m_st[1];
        reg_wr = wr; reg_waddr = wa; reg_wdata = wd;
        cap_chunk_done = cd; play_chunk_done = pd; link_err = le;
        play_smp_vld = sv; play_smp_in = si;
        for (int c = 0; c < 2; c++) begin
            logic [7:0] hw = (c == 0) ? m_wp[c] : m_rp[c];
            logic [7:0] sw = (c == 0) ? m_rp[c] : m_wp[c];
            logic [7:0] nx = 8'((int'(hw) + 1) % ring_len(m_size[c]));
            bit blk = (c == 0) ? (nx == sw) : (hw == sw);
            if (wr && wa == 2'(c)) begin
                if (wd[31]) begin
                    m_size[c] = '0; m_en[c] = 1'b0; m_tc[c] = '0; m_tp[c] = '0;
                    m_rp[c] = '0; m_wp[c] = '0; m_st[c] = 0;
                end else begin
                    m_size[c] = wd[30:28]; m_en[c] = wd[27];
                    m_tc[c] = wd[26:24]; m_tp[c] = wd[23:16];
                    if (c == 0) m_rp[c] = wd[15:8]; else m_wp[c] = wd[7:0];
                    if (!wd[27]) begin
                        if (c == 0) m_wp[c] = wd[7:0]; else m_rp[c] = wd[15:8];
                        m_st[c] = 0;
                    end else if (m_st[c] == 0) begin
                        m_st[c] = 1;
                    end
                end
            end else if (m_st[c] == 1) begin
                bit adv = 1'b0;
                if (c == 0) begin
                    if (cd) begin
                        if (blk) begin m_st[c] = 2; setv[0] = 1'b1; end
                        else adv = 1'b1;
                    end
                end else begin
                    if (blk) begin m_st[c] = 2; setv[2] = 1'b1; end
                    else if (pd) adv = 1'b1;
                end
                if (adv) begin
                    if (c == 0) m_wp[c] = nx; else m_rp[c] = nx;
                    if (trig_hit(nx, m_tp[c], m_tc[c])) setv[(c == 0) ? 1 : 3] = 1'b1;
                end
            end else if (m_st[c] == 2) begin
                if (!blk) m_st[c] = 1;
            end
        end
        if (le) setv[15] = 1'b1;
        clr = (wr && wa == 2'd2) ? wd[15:0] : 16'h0;
        m_stat = ((m_stat & ~clr) | setv) & 16'h800F;
        if (wr && wa == 2'd3) m_mask = wd[15:0] & 16'h800F;
        if (pre_play == 0) m_smp = '0;
        else if (pre_play == 1 && sv) m_smp = si;
        @(posedge clk);
        #1;
        for (int a = 0; a < 4; a++) begin
            logic [31:0] v;
            read_reg(a, v);
            check(tag, $sformatf("reg%0d", a), v, exp_reg(a));
        end
        check(tag, "irq", 32'(irq), 32'(|(m_stat & m_mask)));
        check(tag, "smp_out", 32'(play_smp_out), 32'(m_smp));
        check(tag, "cap_run", 32'(cap_run), 32'(m_st[0] == 1));
        check(tag, "play_run", 32'(play_run), 32'(m_st[1] == 1));
        @(negedge clk);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 2'd0, 32'h0, 0, 0, 0, 0, 16'h0);
    endtask

    function automatic logic [31:0] ctl(logic [2:0] sz, bit en, logic [2:0] tc,
                                         logic [7:0] tp, logic [7:0] rp, logic [7:0] wp);
        return {1'b0, sz, en, tc, tp, rp, wp};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, held;
        int cnt;
        void'($urandom(32'h5eed_a0d1));
        rst_n = 1'b0; reg_wr = 0; reg_waddr = 0; reg_wdata = 0; reg_raddr = 0;
        cap_chunk_done = 0; play_chunk_done = 0; link_err = 0;
        play_smp_vld = 0; play_smp_in = 0;
        model_reset();
        repeat (3) @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            read_reg(a, v);
            check("R1", "reset reg", v, 32'h0);
        end
        check("R1", "reset irq", 32'(irq), 32'h0);
        check("R1", "reset smp", 32'(play_smp_out), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        idle("R1");

        // R2: enabled write keeps hardware pointer, loads the rest
        step("R2", 1, 2'd0, ctl(3'd5, 1, 3'd3, 8'h12, 8'h34, 8'h56), 0, 0, 0, 0, 16'h0);
        read_reg(0, v);
        check("R2", "cap wptr kept", {24'h0, v[7:0]}, 32'h0);
        // R7: disabled write loads both pointers, chunks ignored
        step("R7", 1, 2'd0, ctl(3'd5, 0, 3'd3, 8'h12, 8'h34, 8'h05), 0, 0, 0, 0, 16'h0);
        for (int i = 0; i < 3; i++) step("R7", 0, 2'd0, 32'h0, 1, 1, 0, 0, 16'h0);
        read_reg(0, v);
        check("R7", "idle wptr", {24'h0, v[7:0]}, 32'h05);
        step("R7", 1, 2'd0, 32'h0, 0, 0, 0, 0, 16'h0);
        read_reg(0, v);
        check("R7", "zeroed ctl", v, 32'h0);

        // R3: wrap at 8 chunks, size 0 treated as 2
        step("R3", 1, 2'd0, ctl(3'd0, 1, 3'd0, 8'hF0, 8'h80, 8'h00), 0, 0, 0, 0, 16'h0);
        for (int i = 0; i < 9; i++) step("R3", 0, 2'd0, 32'h0, 1, 0, 0, 0, 16'h0);
        read_reg(0, v);
        check("R3", "wrapped wptr", {24'h0, v[7:0]}, 32'h1);

        // R4 code 0: one trigger per pass; R9 set collides with clear each step
        step("R4", 1, 2'd0, 32'h0, 0, 0, 0, 0, 16'h0);
        step("R4", 1, 2'd0, ctl(3'd7, 1, 3'd0, 8'h10, 8'h00, 8'h00), 0, 0, 0, 0, 16'h0);
        cnt = 0;
        for (int i = 0; i < 255; i++) begin
            step("R9", 1, 2'd2, 32'h2, 1, 0, 0, 0, 16'h0);
            read_reg(2, v);
            if (v[1]) cnt++;
        end
        check("R4", "code0 triggers", 32'(cnt), 32'd1);
        // R5: next position equals read pointer
        step("R5", 0, 2'd0, 32'h0, 1, 0, 0, 0, 16'h0);
        read_reg(2, v);
        check("R5", "ovf bit", {31'h0, v[0]}, 32'h1);
        step("R5", 0, 2'd0, 32'h0, 1, 0, 0, 0, 16'h0);
        read_reg(0, v);
        check("R5", "wptr frozen", {24'h0, v[7:0]}, 32'hFF);
        step("R5", 1, 2'd0, ctl(3'd7, 1, 3'd0, 8'h10, 8'h40, 8'h00), 0, 0, 0, 0, 16'h0);
        idle("R5");
        step("R5", 0, 2'd0, 32'h0, 1, 0, 0, 0, 16'h0);
        read_reg(0, v);
        check("R5", "resumed wptr", {24'h0, v[7:0]}, 32'h0);

        // R4 code 7: every second chunk
        step("R4", 1, 2'd0, 32'h0, 0, 0, 0, 0, 16'h0);
        step("R4", 1, 2'd0, ctl(3'd7, 1, 3'd7, 8'h00, 8'h80, 8'h00), 0, 0, 0, 0, 16'h0);
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            step("R4", 1, 2'd2, 32'h2, 1, 0, 0, 0, 16'h0);
            read_reg(2, v);
            if (v[1]) cnt++;
        end
        check("R4", "code7 triggers", 32'(cnt), 32'd50);

        // R6 and R11: playback underflow and sample hold
        step("R6", 1, 2'd1, ctl(3'd2, 0, 3'd0, 8'h00, 8'h00, 8'h00), 0, 0, 0, 1, 16'h1234);
        step("R11", 0, 2'd0, 32'h0, 0, 0, 0, 1, 16'h5678);
        check("R11", "idle zero", 32'(play_smp_out), 32'h0);
        step("R6", 1, 2'd1, ctl(3'd2, 1, 3'd1, 8'h00, 8'h00, 8'h03), 0, 0, 0, 0, 16'h0);
        for (int i = 0; i < 4; i++) step("R6", 0, 2'd0, 32'h0, 0, 1, 0, 1, 16'(16'h100 + i));
        read_reg(2, v);
        check("R6", "udf bit", {31'h0, v[2]}, 32'h1);
        held = 32'(play_smp_out);
        step("R6", 0, 2'd0, 32'h0, 0, 1, 0, 1, 16'hBEEF);
        step("R6", 0, 2'd0, 32'h0, 0, 1, 0, 1, 16'hCAFE);
        check("R6", "repeat sample", 32'(play_smp_out), held);
        read_reg(1, v);
        check("R6", "rptr frozen", {24'h0, v[15:8]}, 32'h3);
        step("R6", 1, 2'd1, ctl(3'd2, 1, 3'd1, 8'h00, 8'h00, 8'h05), 0, 0, 0, 0, 16'h0);
        idle("R6");
        step("R6", 0, 2'd0, 32'h0, 0, 1, 0, 1, 16'h0777);
        read_reg(1, v);
        check("R6", "rptr resumed", {24'h0, v[15:8]}, 32'h4);

        // R9: link error set wins over clear; R10 mask gating
        step("R9", 1, 2'd2, 32'hFFFF, 0, 0, 1, 0, 16'h0);
        read_reg(2, v);
        check("R9", "set wins", {31'h0, v[15]}, 32'h1);
        step("R10", 1, 2'd3, 32'h8000, 0, 0, 0, 0, 16'h0);
        check("R10", "irq on", 32'(irq), 32'h1);
        step("R9", 1, 2'd2, 32'h8000, 0, 0, 0, 0, 16'h0);
        read_reg(2, v);
        check("R9", "cleared", {31'h0, v[15]}, 32'h0);
        check("R10", "irq off", 32'(irq), 32'h0);

        // R8: reset bit clears the channel
        step("R8", 1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0, 0, 16'h0);
        read_reg(0, v);
        check("R8", "cleared ctl", v, 32'h0);

        // mixed random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int op = int'($urandom % 32);
            bit wr = (op < 6);
            logic [1:0] wa = (op < 2) ? 2'd0 : (op < 4) ? 2'd1 : (op == 4) ? 2'd2 : 2'd3;
            logic [31:0] wd;
            if (wa < 2)
                wd = {($urandom % 16) == 0, 3'($urandom), ($urandom % 8) != 0,
                      3'($urandom), 8'($urandom), 8'($urandom % 16), 8'($urandom % 16)};
            else
                wd = $urandom;
            step("R2", wr, wa, wd, 1'($urandom), 1'($urandom), ($urandom % 64) == 0,
                 1'($urandom), 16'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule